// File: doc/BRIEF.md
# Low-Voltage Detect Control and Status Register

This block is the software-facing side of a supply-voltage monitor. A synchronized comparator output reports that the supply has fallen below a selectable trip point. The block captures that event in a sticky flag. Depending on two enable bits, it turns the flag into a level interrupt request, a level reset request, or both. Software can also poll the flag and acknowledge it by writing a one to a dedicated bit.

The trip-point select field drives the analog comparator. Only a power-on reset clears this field, so the chosen threshold survives an ordinary chip reset. All other state is cleared by either reset. The reset-enable bit is write-once: the first bus write after reset decides it, and it then stays fixed until the next reset.

While the low-power-mode indicator is active, the comparator input is ignored, so the flag cannot become set in that state.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: After power-on reset the register reads 0x10: reset enable (bit 4) is 1 and every other bit is 0.
- R2: The read data is laid out as flag at bit 7, interrupt enable at bit 5, reset enable at bit 4 and trip select at bits 1:0. Bits 6, 3 and 2 always read 0, and trip_sel_o equals read bits 1:0.
- R3: A cycle with below_trip_i=1 and low_power_i=0 sets the flag (read bit 7) from the next cycle. The flag then stays 1 until it is acknowledged.
- R4: A write with data bit 6 = 1 clears the flag on the next cycle. A write with bit 6 = 0 leaves the flag unchanged.
- R5: If a detect event and an acknowledge write fall in the same cycle, the flag is 1 afterwards.
- R6: While low_power_i=1, below_trip_i has no effect and a clear flag stays clear.
- R7: Only the first bus write after a reset updates the reset enable (data bit 4). That write locks the bit whatever value it carries, and later writes leave it unchanged.
- R8: A chip reset (rst_ni low) restores flag, interrupt enable, reset enable and the write-once lock to their reset values. It leaves trip select unchanged. Only por_ni clears trip select.
- R9: irq_o equals (flag AND interrupt enable) as it stood in the previous cycle.
- R10: rst_req_o equals (flag AND reset enable) as it stood in the previous cycle.
- R11: Every write loads the interrupt enable from data bit 5 and trip select from data bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous chip reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset |
| below_trip_i | input | 1 | Synchronized comparator output, 1 when the supply is below the trip point |
| low_power_i | input | 1 | 1 while a low-power mode gates detection |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current register read value |
| irq_o | output | 1 | Level interrupt request |
| rst_req_o | output | 1 | Level reset request |
| trip_sel_o | output | 2 | Trip-point select to the comparator |

## Verification
Two functions can fall in the same cycle: a detect event from the comparator and an acknowledge write. The bench provokes the collision by holding below_trip_i high during an acknowledge write, with low_power_i both low and high. A set must win when detection is enabled. The acknowledge must win when low power gates the set. A behavioural model judges every cycle, and direct readback checks confirm that the flag reads 1 after a collision with detection enabled.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned TRIP_W   = 2;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned ACK_BIT  = 6;
  localparam int unsigned IE_BIT   = 5;
  localparam int unsigned RE_BIT   = 4;
  localparam int unsigned TRIP_LSB = 0;
  localparam int unsigned N_REQ    = 2;
  localparam int unsigned REQ_IRQ  = 0;
  localparam int unsigned REQ_RST  = 1;
endpackage

// File: rtl/lvd_sticky_flag.sv
module lvd_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/lvd_once_bit.sv
module lvd_once_bit #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic d_i,
  output logic q_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o      <= RST_VAL;
      locked_q <= 1'b0;
    end else if (wr_i) begin
      if (!locked_q) q_o <= d_i;
      locked_q <= 1'b1;   // any write consumes the chance
    end
  end
endmodule

// File: rtl/lvd_req_gen.sv
module lvd_req_gen #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flag_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_req
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_o[g] <= 1'b0;
      else         req_o[g] <= flag_i & en_i[g];
    end
  end
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
  import lvd_pkg::*;
#(
  parameter logic RE_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              below_trip_i,
  input  logic              low_power_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic [TRIP_W-1:0] trip_sel_o
);
  logic chip_rst_n;
  logic flag, ie_q, re;
  logic [TRIP_W-1:0] trip_q;
  logic [N_REQ-1:0]  req_en, req;
  logic unused_wbits;

  // chip domain also cleared by power-on reset
  assign chip_rst_n = rst_ni & por_ni;

  lvd_sticky_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (chip_rst_n),
    .set_i  (below_trip_i & ~low_power_i),
    .clr_i  (wr_en_i & wdata_i[ACK_BIT]),
    .flag_o (flag)
  );

  lvd_once_bit #(.RST_VAL(RE_RST)) u_re (
    .clk_i  (clk_i),
    .rst_ni (chip_rst_n),
    .wr_i   (wr_en_i),
    .d_i    (wdata_i[RE_BIT]),
    .q_o    (re)
  );

  always_ff @(posedge clk_i or negedge chip_rst_n) begin
    if (!chip_rst_n)  ie_q <= 1'b0;
    else if (wr_en_i) ie_q <= wdata_i[IE_BIT];
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)      trip_q <= '0;
    else if (wr_en_i) trip_q <= wdata_i[TRIP_LSB +: TRIP_W];
  end

  assign req_en[REQ_IRQ] = ie_q;
  assign req_en[REQ_RST] = re;

  lvd_req_gen #(.N(N_REQ)) u_req (
    .clk_i  (clk_i),
    .rst_ni (chip_rst_n),
    .flag_i (flag),
    .en_i   (req_en),
    .req_o  (req)
  );

  always_comb begin
    rdata_o                       = '0;
    rdata_o[FLAG_BIT]             = flag;
    rdata_o[IE_BIT]               = ie_q;
    rdata_o[RE_BIT]               = re;
    rdata_o[TRIP_LSB +: TRIP_W]   = trip_q;
  end

  assign irq_o        = req[REQ_IRQ];
  assign rst_req_o    = req[REQ_RST];
  assign trip_sel_o   = trip_q;
  assign unused_wbits = ^{wdata_i[FLAG_BIT], wdata_i[3:2]};
endmodule

// File: rtl/lvd_ctrl_reg_chk.sv
module lvd_ctrl_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_ni,
  input logic       below_trip_i,
  input logic       low_power_i,
  input logic       wr_en_i,
  input logic       ack_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic [1:0] trip_sel_o
);
  logic any_rst;
  logic seen_wr_q;
  assign any_rst = !(rst_ni && por_ni);

  always_ff @(posedge clk_i or posedge any_rst) begin
    if (any_rst)      seen_wr_q <= 1'b0;
    else if (wr_en_i) seen_wr_q <= 1'b1;
  end

  p_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (any_rst)
    rdata_o[6] == 1'b0 && rdata_o[3:2] == 2'b00 && trip_sel_o == rdata_o[1:0]);

  p_set_r3: assert property (@(posedge clk_i) disable iff (any_rst)
    (below_trip_i && !low_power_i) |=> rdata_o[7]);   // also covers R5

  p_ack_r4: assert property (@(posedge clk_i) disable iff (any_rst)
    (wr_en_i && ack_i && !(below_trip_i && !low_power_i)) |=> !rdata_o[7]);

  p_lp_gate_r6: assert property (@(posedge clk_i) disable iff (any_rst)
    (low_power_i && !rdata_o[7]) |=> !rdata_o[7]);

  p_once_r7: assert property (@(posedge clk_i) disable iff (any_rst)
    seen_wr_q |=> $stable(rdata_o[4]));

  p_irq_r9: assert property (@(posedge clk_i) disable iff (any_rst)
    1'b1 |=> irq_o == $past(rdata_o[7] & rdata_o[5]));

  p_rreq_r10: assert property (@(posedge clk_i) disable iff (any_rst)
    1'b1 |=> rst_req_o == $past(rdata_o[7] & rdata_o[4]));
endmodule

bind lvd_ctrl_reg lvd_ctrl_reg_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_ni       (por_ni),
  .below_trip_i (below_trip_i),
  .low_power_i  (low_power_i),
  .wr_en_i      (wr_en_i),
  .ack_i        (wdata_i[6]),
  .rdata_o      (rdata_o),
  .irq_o        (irq_o),
  .rst_req_o    (rst_req_o),
  .trip_sel_o   (trip_sel_o)
);

// File: tb/lvd_ctrl_reg_bench.sv
module lvd_ctrl_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, por_n = 1'b0;
  logic       bt = 1'b0, lp = 1'b0, wr = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic       irq, rreq;
  logic [1:0] trip;

  int checks = 0, fails = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  lvd_ctrl_reg u_lvd_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .below_trip_i(bt),
    .low_power_i(lp), .wr_en_i(wr), .wdata_i(wd), .rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rreq), .trip_sel_o(trip)
  );

  // behavioural reference
  bit m_flag, m_ie, m_re, m_lock, m_irq, m_rreq;
  bit [1:0] m_trip;
  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n) begin
      m_flag <= 0; m_ie <= 0; m_re <= 1; m_lock <= 0; m_irq <= 0; m_rreq <= 0; m_trip <= 0;
    end else if (!rst_n) begin
      m_flag <= 0; m_ie <= 0; m_re <= 1; m_lock <= 0; m_irq <= 0; m_rreq <= 0;
    end else begin
      m_irq  <= m_flag && m_ie;
      m_rreq <= m_flag && m_re;
      if (bt && !lp)         m_flag <= 1;
      else if (wr && wd[6])  m_flag <= 0;
      if (wr) begin
        m_ie <= wd[5]; m_trip <= wd[1:0];
        if (!m_lock) m_re <= wd[4];
        m_lock <= 1;
      end
    end
  end

  function automatic [7:0] m_rd();
    return {m_flag, 1'b0, m_ie, m_re, 2'b00, m_trip};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk({cur_req, "/rdata"}, rdata, m_rd());
    chk({cur_req, "/R9 irq"}, irq, m_irq);
    chk({cur_req, "/R10 rreq"}, rreq, m_rreq);
    chk({cur_req, "/R2 trip"}, trip, m_trip);
  end

  task automatic step(input bit w, input bit [7:0] d, input bit b, input bit l);
    @(posedge clk); #1;
    wr = w; wd = d; bt = b; lp = l;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0);
  endtask

  task automatic expect_rd(input string req, input bit [7:0] exp);
    @(negedge clk);
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; por_n = 1; rst_n = 1; cmp_on = 1;
    cur_req = "R1";  expect_rd("R1 reset value", 8'h10);
    cur_req = "R11"; step(1, 8'hFF, 0, 0); step(0, 0, 0, 0);
    expect_rd("R2 R11 layout after 0xFF", 8'h33);
    cur_req = "R7";  step(1, 8'h00, 0, 0); step(0, 0, 0, 0);
    expect_rd("R7 re locked", 8'h10);
    cur_req = "R3";  step(0, 0, 1, 0); step(0, 0, 0, 0);
    expect_rd("R3 flag set", 8'h90);
    idle(2);
    chk("R10 reset request", rreq, 1);
    cur_req = "R4";  step(1, 8'h20, 0, 0); step(0, 0, 0, 0);
    expect_rd("R4 zero ack keeps flag", 8'hB0);
    idle(1);
    chk("R9 interrupt", irq, 1);
    step(1, 8'h60, 0, 0); step(0, 0, 0, 0);
    expect_rd("R4 ack clears", 8'h30);
    idle(2);
    chk("R9 irq drops", irq, 0);
    cur_req = "R5";  step(1, 8'h40, 1, 0); step(0, 0, 0, 0);
    expect_rd("R5 set wins", 8'h90);
    cur_req = "R6";  step(1, 8'h40, 1, 1); step(0, 0, 1, 1); step(0, 0, 1, 1); step(0, 0, 0, 0);
    expect_rd("R6 low power gates set", 8'h10);
    cur_req = "R8";  step(1, 8'hA2, 1, 0); step(0, 0, 0, 0);
    @(posedge clk); #1; rst_n = 0;
    @(posedge clk); #1; rst_n = 1;
    expect_rd("R8 chip reset keeps trip", 8'h12);
    step(1, 8'h02, 0, 0); step(1, 8'h12, 0, 0); step(0, 0, 0, 0);
    expect_rd("R7 first write after chip reset", 8'h02);
    @(posedge clk); #1; por_n = 0;
    @(posedge clk); #1; por_n = 1;
    expect_rd("R8 R1 por clears trip", 8'h10);
    cur_req = "R3-R11 random";
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) == 0, 8'($urandom), ($urandom % 3) == 0, ($urandom % 4) == 0);
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule